// File: doc/BRIEF.md
# Host Register Window with Direct and Indirect Access

This block sits between an asynchronous, SRAM-style host port and a chip's internal register bus. The host sees only sixteen locations, selected by a 4-bit address. Fourteen of them map one-to-one onto internal registers 0 to 13. The remaining two form a pointer/data pair. The pointer location holds an internal address. The data location reads or writes the internal register that the pointer names. Through this pair the host reaches the whole internal register space.

The chip-select, read and write strobes are not tied to the core clock, so they are brought into the core clock domain before any decoding. Each strobe assertion yields exactly one access, however long the strobe is held. Address and write data are assumed stable while the strobe is asserted.

The control path can be 32 bits wide or 16 bits wide. This choice is made by a static configuration input and does not depend on how wide the data path is. In 16-bit mode every 32-bit register is moved as two halfwords, the upper one first. Each halfword travels left-justified on the top half of the bus. A register write takes effect only when the lower halfword arrives. A register read takes a snapshot on the upper halfword, so the two halves always belong together. An optional auto-increment bit in the pointer register lets the host stream through consecutive internal registers.

Top module: `hrw_window`

## Requirements
- R1: After reset, `hdata_out` is 0, `reg_we` and `reg_re` are 0, and reading host location 14 returns 0.
- R2: In 32-bit mode (`ctl_wide`=1), a host write to location 0..13 produces one single-cycle `reg_we` pulse with `reg_addr` equal to the host address and `reg_wdata` equal to the full 32-bit host data.
- R3: In 32-bit mode, a host read of location 0..13 returns the internal register at that address on `hdata_out`. `hdata_out` changes only when a read completes, and it stays stable while the read strobe is held, even if the internal register changes.
- R4: Location 14 is the pointer register. Bits [7:0] hold the internal address and bit 31 is the auto-increment enable. Writing it produces no `reg_we`, and reading it returns {bit31, zeros, pointer}.
- R5: A host write to location 15 writes the internal register named by the pointer. A host read of location 15 returns that register's contents.
- R6: When pointer bit 31 is 1, the pointer advances by one after each completed location-15 access, wrapping from 255 to 0. The access itself uses the value before the advance. When bit 31 is 0, the pointer does not change.
- R7: In 16-bit mode (`ctl_wide`=0), each halfword is carried on bus bits [31:16], and `hdata_out[15:0]` reads as 0. Accesses alternate upper then lower, starting with upper. An upper-half write produces no `reg_we`; the lower-half write commits {upper, lower}.
- R8: In 16-bit mode, the upper-half read fetches the whole register. The following lower-half read returns the low half of that same fetch, even if the register has changed in between.
- R9: A strobe acts only after it has passed two synchronising flip-flops. `reg_we` is still 0 two clock edges after a write strobe asserts and is 1 after the third. A strobe with `hcs_n` high has no effect, and a strobe held for many cycles gives exactly one access.
- R10: In 16-bit mode with auto-increment on, the pointer advances once per halfword pair, after the lower half, for both reads and writes of location 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wide | input | 1 | Control width: 1 = 32-bit, 0 = 16-bit halfword pairs (static) |
| hcs_n | input | 1 | Host chip select, active low, asynchronous |
| hrd_n | input | 1 | Host read strobe, active low, asynchronous |
| hwr_n | input | 1 | Host write strobe, active low, asynchronous |
| haddr | input | 4 | Host location select |
| hdata_in | input | 32 | Host write data; in 16-bit mode only [31:16] is used |
| hdata_out | output | 32 | Host read data, held until the next read completes |
| reg_addr | output | 8 | Internal register bus address |
| reg_wdata | output | 32 | Internal register bus write data |
| reg_we | output | 1 | Internal write pulse |
| reg_re | output | 1 | Internal read pulse; `reg_rdata` is sampled one cycle later |
| reg_rdata | input | 32 | Internal register bus read data |

## Verification
Two things can happen in the same clock edge: a location-15 access issues its internal bus address, and the auto-incrementing pointer moves on. The bench provokes this with back-to-back auto-increment writes and reads. It also pushes the pointer to 255 so that the increment wraps. It then judges the result by the registers that were written, the data that comes back, and the pointer value read from location 14. In 16-bit mode the same collision is moved to the lower-half access, and a pointer readback confirms that only one step happened per pair.

// File: rtl/hrw_pkg.sv
package hrw_pkg;

  typedef enum logic [1:0] {
    LOC_DIRECT = 2'd0,
    LOC_INDEX  = 2'd1,
    LOC_DATA   = 2'd2
  } loc_e;

  // The top two host locations form the pointer/data pair.
  function automatic loc_e decode_loc(input int unsigned a, input int unsigned nloc);
    if (a == nloc - 2)      return LOC_INDEX;
    else if (a == nloc - 1) return LOC_DATA;
    else                    return LOC_DIRECT;
  endfunction

endpackage

// File: rtl/hrw_sync.sv
module hrw_sync #(
  parameter int unsigned W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        sync_q <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        sync_q <= meta_q;
      end
    end

    assign q[i] = sync_q;
  end

endmodule

// File: rtl/hrw_strobe.sv
module hrw_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_s,
  input  logic rd_n_s,
  input  logic wr_n_s,
  output logic start_rd,
  output logic start_wr
);

  logic act;
  logic prev_q;
  logic start;

  assign act      = ~cs_n_s & (~rd_n_s | ~wr_n_s);
  assign start    = act & ~prev_q;
  assign start_wr = start & ~wr_n_s;
  assign start_rd = start &  wr_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= act;
  end

endmodule

// File: rtl/hrw_lane.sv
module hrw_lane #(
  parameter int unsigned BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide,
  input  logic             start_rd,
  input  logic             start_wr,
  input  logic [BUS_W-1:0] host_wdata,
  input  logic             rd_load,
  input  logic [BUS_W-1:0] rd_full,
  output logic             commit,
  output logic             fetch,
  output logic             pair_end,
  output logic [BUS_W-1:0] wr_word,
  output logic [BUS_W-1:0] hout
);

  localparam int unsigned HALF = BUS_W / 2;

  logic            phase_lo_q, phase_lo_d;
  logic [HALF-1:0] whold_q, whold_d;
  logic            whold_en;
  logic [BUS_W-1:0] rsnap_q, rsnap_d;
  logic            rsnap_en;
  logic [BUS_W-1:0] hout_q, hout_d;
  logic            hout_en;
  logic            start_any;
  logic            low_rd;

  assign start_any = start_rd | start_wr;
  assign pair_end  = start_any & (wide | phase_lo_q);
  assign commit    = start_wr & (wide | phase_lo_q);
  assign fetch     = start_rd & (wide | ~phase_lo_q);
  assign low_rd    = start_rd & ~wide & phase_lo_q;
  assign wr_word   = wide ? host_wdata : {whold_q, host_wdata[BUS_W-1:HALF]};
  assign hout      = hout_q;

  always_comb begin
    phase_lo_d = wide ? 1'b0 : (start_any ? ~phase_lo_q : phase_lo_q);
    whold_en   = start_wr & ~wide & ~phase_lo_q;
    whold_d    = host_wdata[BUS_W-1:HALF];
    rsnap_en   = rd_load;
    rsnap_d    = rd_full;
    hout_en    = rd_load | low_rd;
    if (rd_load) hout_d = wide ? rd_full : {rd_full[BUS_W-1:HALF], {HALF{1'b0}}};
    else         hout_d = {rsnap_q[HALF-1:0], {HALF{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_lo_q <= 1'b0;
      whold_q    <= '0;
      rsnap_q    <= '0;
      hout_q     <= '0;
    end else begin
      phase_lo_q <= phase_lo_d;
      if (whold_en) whold_q <= whold_d;
      if (rsnap_en) rsnap_q <= rsnap_d;
      if (hout_en)  hout_q  <= hout_d;
    end
  end

  // R7: once settled in halfword mode, the low half of the host output is zero
  a_r7_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && $past(!wide) && $past(hout_en)) |-> (hout_q[HALF-1:0] == '0));

endmodule

// File: rtl/hrw_window.sv
module hrw_window #(
  parameter int unsigned AW    = 4,
  parameter int unsigned BUS_W = 32,
  parameter int unsigned IW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wide,
  input  logic             hcs_n,
  input  logic             hrd_n,
  input  logic             hwr_n,
  input  logic [AW-1:0]    haddr,
  input  logic [BUS_W-1:0] hdata_in,
  output logic [BUS_W-1:0] hdata_out,
  output logic [IW-1:0]    reg_addr,
  output logic [BUS_W-1:0] reg_wdata,
  output logic             reg_we,
  output logic             reg_re,
  input  logic [BUS_W-1:0] reg_rdata
);
  import hrw_pkg::*;

  localparam int unsigned NLOC = 1 << AW;
  localparam int unsigned AINC_BIT = BUS_W - 1;

  logic [2:0] strb_s;
  logic       start_rd, start_wr;
  loc_e       loc;
  logic       commit, fetch, pair_end;
  logic [BUS_W-1:0] wr_word, rd_full, idx_word;
  logic [IW-1:0]    tgt;

  logic [IW-1:0]    ptr_q, ptr_d;
  logic             ainc_q, ainc_d;
  logic             we_q, we_d, re_q, re_d;
  logic [IW-1:0]    addr_q, addr_d;
  logic [BUS_W-1:0] wdata_q, wdata_d;
  logic             pend_q, pend_d;
  logic             pidx_q, pidx_d;

  hrw_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({hcs_n, hrd_n, hwr_n}), .q(strb_s)
  );

  hrw_strobe u_strobe (
    .clk(clk), .rst_n(rst_n),
    .cs_n_s(strb_s[2]), .rd_n_s(strb_s[1]), .wr_n_s(strb_s[0]),
    .start_rd(start_rd), .start_wr(start_wr)
  );

  hrw_lane #(.BUS_W(BUS_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .wide(ctl_wide),
    .start_rd(start_rd), .start_wr(start_wr), .host_wdata(hdata_in),
    .rd_load(pend_q), .rd_full(rd_full),
    .commit(commit), .fetch(fetch), .pair_end(pair_end),
    .wr_word(wr_word), .hout(hdata_out)
  );

  assign loc = decode_loc(int'(haddr), NLOC);
  assign tgt = (loc == LOC_DATA) ? ptr_q : {{(IW-AW){1'b0}}, haddr};

  always_comb begin
    idx_word           = '0;
    idx_word[IW-1:0]   = ptr_q;
    idx_word[AINC_BIT] = ainc_q;
  end

  assign rd_full = pidx_q ? idx_word : reg_rdata;

  always_comb begin
    ptr_d   = ptr_q;
    ainc_d  = ainc_q;
    we_d    = 1'b0;
    re_d    = 1'b0;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    pend_d  = 1'b0;
    pidx_d  = pidx_q;
    if (commit) begin
      if (loc == LOC_INDEX) begin
        ptr_d  = wr_word[IW-1:0];
        ainc_d = wr_word[AINC_BIT];
      end else begin
        we_d    = 1'b1;
        addr_d  = tgt;
        wdata_d = wr_word;
      end
    end
    if (fetch) begin
      pend_d = 1'b1;
      pidx_d = (loc == LOC_INDEX);
      if (loc != LOC_INDEX) begin
        re_d   = 1'b1;
        addr_d = tgt;
      end
    end
    if (pair_end && (loc == LOC_DATA) && ainc_q) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      ainc_q  <= 1'b0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      pend_q  <= 1'b0;
      pidx_q  <= 1'b0;
    end else begin
      ptr_q   <= ptr_d;
      ainc_q  <= ainc_d;
      we_q    <= we_d;
      re_q    <= re_d;
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      pend_q  <= pend_d;
      pidx_q  <= pidx_d;
    end
  end

  assign reg_we    = we_q;
  assign reg_re    = re_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;

  // R2: an internal write is a single-cycle pulse
  a_r2_we_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R9: no access starts unless chip select was low two edges earlier
  a_r9_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rd || start_wr) |-> $past(!hcs_n, 2));

  // R6: an auto-incrementing data access moves the pointer by exactly one
  a_r6_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_end && (loc == LOC_DATA) && ainc_q) |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R3: host read data only moves when a read is being completed
  a_r3_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_rd && !pend_q) |=> $stable(hdata_out));

endmodule

// File: tb/hrw_window_bench.sv
module hrw_window_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_wide;
  logic        hcs_n, hrd_n, hwr_n;
  logic [3:0]  haddr;
  logic [31:0] hdata_in, hdata_out;
  logic [7:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_we, reg_re;

  logic [31:0] mem [256];
  logic [31:0] expm [256];
  int          we_cnt;
  logic        poke_en;
  logic [7:0]  poke_a;
  logic [31:0] poke_d;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  hrw_window u_hrw_window (
    .clk(clk), .rst_n(rst_n), .ctl_wide(ctl_wide),
    .hcs_n(hcs_n), .hrd_n(hrd_n), .hwr_n(hwr_n), .haddr(haddr),
    .hdata_in(hdata_in), .hdata_out(hdata_out),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
      we_cnt <= 0;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_cnt <= we_cnt + 1;
    end else if (poke_en) begin
      mem[poke_a] <= poke_d;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] idx_val(input bit ai, input logic [7:0] p);
    return {ai, 23'd0, p};
  endfunction

  function automatic logic [31:0] upper16(input logic [31:0] v);
    return {v[31:16], 16'h0000};
  endfunction

  task automatic host_op(input bit wr, input logic [3:0] a, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    haddr = a; hdata_in = d; hcs_n = 1'b0;
    if (wr) hwr_n = 1'b0; else hrd_n = 1'b0;
    repeat (6) @(negedge clk);
    q = hdata_out;
    hcs_n = 1'b1; hwr_n = 1'b1; hrd_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    logic [31:0] q;
    host_op(1'b1, a, d, q);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] q);
    host_op(1'b0, a, 32'h0, q);
  endtask

  task automatic poke(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    poke_a = a; poke_d = d; poke_en = 1'b1;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] q, v1, v2, d;
    logic [7:0]  mptr;
    bit          mai;
    int          c0;
    void'($urandom(32'd4711));
    rst_n = 1'b0; ctl_wide = 1'b1; hcs_n = 1'b1; hrd_n = 1'b1; hwr_n = 1'b1;
    haddr = '0; hdata_in = '0; poke_en = 1'b0; poke_a = '0; poke_d = '0;
    for (int i = 0; i < 256; i++) expm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(hdata_out == 0, "R1 hdata_out", hdata_out, 0);
    chk(!reg_we && !reg_re, "R1 bus idle", {30'd0, reg_we, reg_re}, 0);
    rd(4'd14, q);
    chk(q == 0, "R1 pointer", q, 0);

    // R9 timing / R2 single write
    c0 = we_cnt;
    d = 32'hA5C3_0F01;
    @(negedge clk);
    haddr = 4'd5; hdata_in = d; hcs_n = 1'b0; hwr_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(reg_we == 1'b0, "R9 two-edge delay", {31'd0, reg_we}, 0);
    @(negedge clk);
    chk(reg_we && reg_addr == 8'd5 && reg_wdata == d, "R2 write pulse", reg_wdata, d);
    repeat (20) @(negedge clk);
    hcs_n = 1'b1; hwr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(we_cnt == c0 + 1, "R9 one access per strobe", we_cnt, c0 + 1);
    chk(mem[5] == d, "R2 write data", mem[5], d);
    expm[5] = d;

    // R9: strobe without chip select does nothing
    c0 = we_cnt;
    @(negedge clk);
    haddr = 4'd5; hdata_in = 32'h1111_2222; hwr_n = 1'b0;
    repeat (8) @(negedge clk);
    hwr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(we_cnt == c0, "R9 no chip select", we_cnt, c0);
    rd(4'd5, q);
    chk(q == d, "R9 register untouched", q, d);

    // R3: output held while the read strobe stays asserted
    @(negedge clk);
    haddr = 4'd5; hcs_n = 1'b0; hrd_n = 1'b0;
    repeat (6) @(negedge clk);
    v1 = hdata_out;
    poke(8'd5, 32'hDEAD_0005);
    repeat (4) @(negedge clk);
    v2 = hdata_out;
    hcs_n = 1'b1; hrd_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(v1 == d && v2 == d, "R3 held read data", v2, d);
    expm[5] = 32'hDEAD_0005;

    // R2/R3: random direct traffic
    for (int i = 0; i < 14; i++) begin
      d = $urandom; wr(i[3:0], d); expm[i] = d;
    end
    for (int i = 0; i < 40; i++) begin
      logic [3:0] a;
      a = 4'($urandom % 14);
      if ($urandom % 2) begin
        d = $urandom; wr(a, d); expm[a] = d;
        chk(mem[a] == d, "R2 random write", mem[a], d);
      end else begin
        rd(a, q);
        chk(q == expm[a], "R3 random read", q, expm[a]);
      end
    end

    // R4/R5: pointer and data pair without increment
    c0 = we_cnt;
    wr(4'd14, 32'h0000_0040);
    chk(we_cnt == c0, "R4 no internal write", we_cnt, c0);
    rd(4'd14, q);
    chk(q == 32'h40, "R4 pointer readback", q, 32'h40);
    d = 32'h0BAD_F00D;
    wr(4'd15, d);
    chk(mem[8'h40] == d, "R5 indirect write", mem[8'h40], d);
    rd(4'd15, q);
    chk(q == d, "R5 indirect read", q, d);
    rd(4'd14, q);
    chk(q == 32'h40, "R6 no advance when off", q, 32'h40);

    // R6: auto-increment, access and advance in the same edge
    wr(4'd14, 32'h8000_0050);
    wr(4'd15, 32'h1234_5678);
    wr(4'd15, 32'h9ABC_DEF0);
    rd(4'd14, q);
    chk(q == 32'h8000_0052, "R6 pointer after writes", q, 32'h8000_0052);
    chk(mem[8'h50] == 32'h1234_5678 && mem[8'h51] == 32'h9ABC_DEF0, "R6 written pair", mem[8'h51], 32'h9ABC_DEF0);
    wr(4'd14, 32'h8000_0050);
    rd(4'd15, v1);
    rd(4'd15, v2);
    chk(v1 == 32'h1234_5678, "R6 first read old pointer", v1, 32'h1234_5678);
    chk(v2 == 32'h9ABC_DEF0, "R6 second read next", v2, 32'h9ABC_DEF0);

    // R6: wrap at the top of the space
    wr(4'd14, 32'h8000_00FF);
    wr(4'd15, 32'hC0DE_00FF);
    chk(mem[8'hFF] == 32'hC0DE_00FF, "R6 write at 255", mem[8'hFF], 32'hC0DE_00FF);
    rd(4'd14, q);
    chk(q == 32'h8000_0000, "R6 wrap", q, 32'h8000_0000);

    // R5/R6: random indirect traffic against a pointer model
    for (int i = 0; i < 20; i++) begin
      mptr = 8'($urandom); mai = 1'($urandom);
      wr(4'd14, idx_val(mai, mptr));
      d = $urandom;
      wr(4'd15, d);
      chk(mem[mptr] == d, "R5 random indirect write", mem[mptr], d);
      if (mai) mptr = mptr + 8'd1;
      rd(4'd14, q);
      chk(q == idx_val(mai, mptr), "R6 random pointer", q, idx_val(mai, mptr));
    end

    // R7/R8: 16-bit control mode
    ctl_wide = 1'b0;
    repeat (2) @(negedge clk);
    c0 = we_cnt;
    wr(4'd3, 32'hAAAA_1357);
    chk(we_cnt == c0, "R7 upper half no commit", we_cnt, c0);
    wr(4'd3, 32'h5555_2468);
    chk(mem[3] == 32'hAAAA_5555, "R7 commit on lower", mem[3], 32'hAAAA_5555);
    rd(4'd3, q);
    chk(q == 32'hAAAA_0000, "R7 upper read left-justified", q, 32'hAAAA_0000);
    poke(8'd3, 32'h7777_8888);
    rd(4'd3, q);
    chk(q == 32'h5555_0000, "R8 lower from snapshot", q, 32'h5555_0000);
    rd(4'd3, v1);
    rd(4'd3, v2);
    chk(v1 == upper16(32'h7777_8888) && v2 == 32'h8888_0000, "R8 fresh pair", v2, 32'h8888_0000);

    // R10: one pointer step per halfword pair
    wr(4'd14, 32'h8000_0000);
    wr(4'd14, 32'h0020_0000);
    wr(4'd15, 32'h1111_0000);
    wr(4'd15, 32'h2222_0000);
    chk(mem[8'h20] == 32'h1111_2222, "R10 pair write", mem[8'h20], 32'h1111_2222);
    rd(4'd14, v1);
    rd(4'd14, v2);
    chk(v1 == 32'h8000_0000 && v2 == 32'h0021_0000, "R10 step after write pair", v2, 32'h0021_0000);
    poke(8'h21, 32'hFACE_B00C);
    rd(4'd15, v1);
    rd(4'd15, v2);
    chk(v1 == 32'hFACE_0000 && v2 == 32'hB00C_0000, "R10 pair read", v2, 32'hB00C_0000);
    rd(4'd14, v1);
    rd(4'd14, v2);
    chk(v2 == 32'h0022_0000, "R10 step after read pair", v2, 32'h0022_0000);

    // back to 32-bit mode
    ctl_wide = 1'b1;
    repeat (2) @(negedge clk);
    rd(4'd14, q);
    chk(q == 32'h8000_0022, "R4 pointer in wide mode", q, 32'h8000_0022);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule